// File: doc/BRIEF.md
# Bidirectional Storage Transceiver Datapath

This block is the logic core of an 8-bit bidirectional transceiver. Data moves from the A side to the B side through one storage element, and from the B side back to the A side through a second element. Each element is set at run time by its own two-bit select. It can capture on the rising edge of its direction's strobe, act as a latch that is transparent while the strobe is high, or pass its input straight through. Data is always inverted on the way across.

The A side has a separate input bus and a separate output bus. The output bus is qualified by an enable that drives the pad's three-state control. The B side is an open-drain bus. The block produces a per-bit pull-low request and reads back the sampled bus level. The pad must resolve an undriven line to 0 before it reaches the block.

A loopback input replaces the B-bus input of the return element with the forward element's uninverted result. This lets the A side read back what it would send.

Top module: `bidir_xcvr`

## Requirements
- R1: Each select is decoded as follows: bit1=1 gives pass-through whatever bit0 is; bit1=0 with bit0=1 gives transparent latch; 00 gives register.
- R2: In register mode the element loads its input only on a clock edge where its strobe is high and was low on the previous clock. With the strobe held high, later input changes are not taken.
- R3: In latch mode, while the strobe is high the element follows its input within the same cycle. While the strobe is low the element keeps the last value it held.
- R4: Data is inverted across the block in every mode. `b_pull[i]`=1, which pulls bus bit i low, when the forward element's bit is 1 and the driver is on. `a_out` is the bitwise inverse of the return element's value.
- R5: The B driver is on only when `b_en_p`=1 and `b_en_n`=0. In every other combination, `b_pull` is all zeros, so the bus floats high.
- R6: `a_oe` equals `a_en` in the same cycle. `a_out` carries the return value whatever `a_en` is.
- R7: Either element keeps loading and holding while its direction's outputs are disabled. Once re-enabled, the output shows the value loaded meanwhile.
- R8: With `loopback`=1, the return element takes the forward element's uninverted value as its input, and `b_in` has no effect.
- R9: A synchronous reset clears both stored values and both strobe histories to 0. A strobe that is already high when reset ends counts as a rising edge.
- R10: A select change takes effect in the same cycle. Entering pass-through shows the live inverted input. Leaving it shows the retained stored value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | A-side input bus |
| a_out | output | 8 | A-side output data (inverted return value) |
| a_oe | output | 1 | A-side output enable for the three-state pad |
| a_en | input | 1 | A output enable request |
| b_in | input | 8 | Sampled B-bus level |
| b_pull | output | 8 | Per-bit pull-low request for the B bus |
| b_en_p | input | 1 | B driver enable, active high |
| b_en_n | input | 1 | B driver enable, active low |
| sel_ab | input | 2 | Forward element select |
| sel_ba | input | 2 | Return element select |
| stb_ab | input | 1 | Forward clock / latch enable |
| stb_ba | input | 1 | Return clock / latch enable |
| loopback | input | 1 | Routes forward value into the return element |

## Verification
Loopback and return-element storage can act in the same cycle. The return element can capture the forward element's value on the cycle the forward latch is transparent. The bench provokes this by opening the forward latch on a new value while it pulses the return strobe in register mode. The result is judged by whether `a_out` settles to the inverse of that new value, with `b_in` set to a conflicting pattern. Storage loading during a disabled driver is also provoked together with a strobe edge. The released outputs are checked first, and then the value that appears on re-enable.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {XM_REG = 2'd0, XM_LAT = 2'd1, XM_PASS = 2'd2} xmode_e;

  // Two-bit select: high bit forces pass-through, else low bit picks latch
  function automatic xmode_e decode_mode(input logic [1:0] sel);
    if (sel[1])      return XM_PASS;
    else if (sel[0]) return XM_LAT;
    else             return XM_REG;
  endfunction

  // Driver gating: on only for the one enable pair combination
  function automatic logic drv_on(input logic en_p, input logic en_n);
    return en_p & ~en_n;
  endfunction
endpackage

// File: rtl/xcvr_elem.sv
module xcvr_elem #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         cap
);
  import xcvr_pkg::*;

  xmode_e       mode;
  logic         stb_q;
  logic         stb_rise;
  logic [W-1:0] held;

  assign mode     = decode_mode(sel);
  assign stb_rise = stb & ~stb_q;
  assign cap      = ((mode == XM_REG) & stb_rise) | ((mode == XM_LAT) & stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb;
      if (cap) held <= din;
    end
  end

  always_comb begin
    case (mode)
      XM_PASS: dout = din;
      XM_LAT:  dout = stb ? din : held;
      default: dout = held;
    endcase
  end
endmodule

// File: rtl/xcvr_bdrv.sv
module xcvr_bdrv #(
  parameter int W = 8
) (
  input  logic         en_p,
  input  logic         en_n,
  input  logic [W-1:0] val,
  output logic         on,
  output logic [W-1:0] pull
);
  import xcvr_pkg::*;

  assign on = drv_on(en_p, en_n);

  // Bus level is ~val; a 0 on the bus means pull that bit low
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pull[i] = on & val[i];
  end
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic         a_en,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pull,
  input  logic         b_en_p,
  input  logic         b_en_n,
  input  logic [1:0]   sel_ab,
  input  logic [1:0]   sel_ba,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         loopback
);
  logic [W-1:0] ab_val;
  logic [W-1:0] ba_val;
  logic [W-1:0] ba_src;
  logic         ab_cap;
  logic         ba_cap;
  logic         b_on;

  xcvr_elem #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .sel(sel_ab), .stb(stb_ab),
    .din(a_in), .dout(ab_val), .cap(ab_cap)
  );

  assign ba_src = loopback ? ab_val : b_in;

  xcvr_elem #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .sel(sel_ba), .stb(stb_ba),
    .din(ba_src), .dout(ba_val), .cap(ba_cap)
  );

  xcvr_bdrv #(.W(W)) u_bdrv (
    .en_p(b_en_p), .en_n(b_en_n), .val(ab_val), .on(b_on), .pull(b_pull)
  );

  assign a_out = ~ba_val;
  assign a_oe  = a_en;
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_pull,
  input logic         b_en_p,
  input logic         b_en_n,
  input logic [1:0]   sel_ab,
  input logic [1:0]   sel_ba,
  input logic         stb_ab,
  input logic         loopback,
  input logic         ab_cap,
  input logic [W-1:0] ab_val
);
  // R5
  b_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(b_en_p && !b_en_n) |-> (b_pull == '0));

  // R2
  reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_cap && sel_ab == 2'b00) |=> (sel_ab != 2'b00 || ab_val == $past(a_in)));

  // R3
  latch_open_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ab == 2'b01 && stb_ab && b_en_p && !b_en_n) |-> (b_pull == a_in));

  // R1
  pass_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ab[1] && b_en_p && !b_en_n) |-> (b_pull == a_in));

  // R8
  loop_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (loopback && sel_ab[1] && sel_ba[1]) |-> (a_out == ~a_in));
endmodule

bind bidir_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .b_pull(b_pull),
  .b_en_p(b_en_p), .b_en_n(b_en_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .stb_ab(stb_ab), .loopback(loopback), .ab_cap(ab_cap), .ab_val(ab_val)
);

// File: tb/sim_bidir_xcvr.sv
module sim_bidir_xcvr;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] a_in, b_in, a_out, b_pull;
  logic       a_oe, a_en, b_en_p, b_en_n, stb_ab, stb_ba, loopback;
  logic [1:0] sel_ab, sel_ba;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_xcvr #(.W(8)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_en(a_en),
    .b_in(b_in), .b_pull(b_pull), .b_en_p(b_en_p), .b_en_n(b_en_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
    .loopback(loopback)
  );

  typedef struct packed {
    logic [7:0] a; logic [7:0] b; logic [1:0] sab; logic [1:0] sba;
    logic ep; logic en; logic ae; logic lb;
    logic [7:0] x_pull; logic [7:0] x_aout; logic x_oe;
  } vec_t;

  // pass-through vectors: bus pull = a when driver on, a_out = ~source
  localparam vec_t TBL [6] = '{
    '{8'hA5, 8'h3C, 2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hC3, 1'b1},
    '{8'h0F, 8'hFF, 2'b10, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    '{8'hF0, 8'h00, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1},
    '{8'h81, 8'h55, 2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b1},
    '{8'h3C, 8'h81, 2'b11, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h7E, 1'b1},
    '{8'hFF, 8'h00, 2'b10, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; a_en = 1'b1; b_en_p = 1'b1; b_en_n = 1'b0;
    sel_ab = 2'b00; sel_ba = 2'b00; stb_ab = 1'b0; stb_ba = 1'b0; loopback = 1'b0;
    step(); step();
    rst = 1'b0;
    settle();
    // R9: reset clears stored values, register mode exposes them
    chk("R9 fwd reset", b_pull, 8'h00);
    chk("R9 ret reset", a_out, 8'hFF);

    // R1 R4 R5 R6 R8: vector walk
    foreach (TBL[i]) begin
      a_in = TBL[i].a; b_in = TBL[i].b; sel_ab = TBL[i].sab; sel_ba = TBL[i].sba;
      b_en_p = TBL[i].ep; b_en_n = TBL[i].en; a_en = TBL[i].ae; loopback = TBL[i].lb;
      settle();
      chk("R5 R4 vec pull", b_pull, TBL[i].x_pull);
      chk("R1 R8 vec aout", a_out, TBL[i].x_aout);
      chk("R6 vec oe", {7'd0, a_oe}, {7'd0, TBL[i].x_oe});
      step();
    end

    // R2: register mode forward
    loopback = 1'b0; sel_ab = 2'b00; b_en_p = 1'b1; b_en_n = 1'b0; a_en = 1'b1;
    a_in = 8'h5A; stb_ab = 1'b0;
    step();
    chk("R2 no edge no load", b_pull, 8'h00);
    stb_ab = 1'b1;
    step();
    chk("R2 load on rise", b_pull, 8'h5A);
    a_in = 8'hC3;
    step();
    chk("R2 held strobe no load", b_pull, 8'h5A);
    stb_ab = 1'b0;
    step();
    // R7: load while driver released
    b_en_n = 1'b1; stb_ab = 1'b1;
    step();
    chk("R7 released", b_pull, 8'h00);
    b_en_n = 1'b0; settle();
    chk("R7 loaded while off", b_pull, 8'hC3);

    // R3: latch mode
    sel_ab = 2'b01; a_in = 8'h11; settle();
    chk("R3 transparent", b_pull, 8'h11);
    step();
    stb_ab = 1'b0; a_in = 8'h22; settle();
    chk("R3 hold low", b_pull, 8'h11);
    step();
    chk("R3 hold later", b_pull, 8'h11);
    // R10: mode switching
    sel_ab = 2'b10; settle();
    chk("R10 into pass", b_pull, 8'h22);
    sel_ab = 2'b01; settle();
    chk("R10 back to stored", b_pull, 8'h11);

    // R8: loopback with return pass-through, b_in ignored
    loopback = 1'b1; sel_ba = 2'b10; b_in = 8'h00; settle();
    chk("R8 loop pass", a_out, 8'hEE);
    b_in = 8'hFF; settle();
    chk("R8 b ignored", a_out, 8'hEE);
    // R8 R2: forward latch opens while return register captures
    sel_ba = 2'b00; stb_ba = 1'b0; step();
    chk("R2 ret reg held", a_out, 8'hFF);
    stb_ab = 1'b1; a_in = 8'h66; stb_ba = 1'b1; b_in = 8'h99;
    step();
    chk("R8 ret captured fwd", a_out, 8'h99);
    stb_ab = 1'b0; stb_ba = 1'b0;

    // R3 R6 R7: return latch with A output disabled
    loopback = 1'b0; sel_ba = 2'b01; a_en = 1'b0; b_in = 8'h0F; stb_ba = 1'b1;
    settle();
    chk("R6 oe off", {7'd0, a_oe}, 8'h00);
    chk("R3 R7 ret transparent", a_out, 8'hF0);
    step();
    stb_ba = 1'b0; b_in = 8'h33; a_en = 1'b1; settle();
    chk("R7 ret held", a_out, 8'hF0);

    // R9: mid-run reset
    sel_ab = 2'b00; sel_ba = 2'b00; rst = 1'b1;
    step();
    rst = 1'b0; settle();
    chk("R9 fwd cleared", b_pull, 8'h00);
    chk("R9 ret cleared", a_out, 8'hFF);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule